// File: doc/BRIEF.md
# GPIO Port Controller with Peripheral Multiplexing

This block controls one port of up to 32 I/O pads. Each pin belongs either to the general-purpose I/O logic or to one of four internal peripheral functions, labelled A to D. Software configures the port through a small word-addressed register interface with address, write data, write enable and read data. Most settings use a write-one-to-set address, a write-one-to-clear address and a status address that can be read back. A write to a set or clear address changes only the pins whose write-data bit is 1, so no read-modify-write is needed.

The block drives the pad output value, the pad output enable, the pull-up and pull-down controls and a Schmitt-trigger disable line. It returns the raw pad level to software whichever function owns the pin. It also gives the peripherals a copy of the input, which can be passed through a glitch filter or a debounce filter. The register port and all pad and peripheral signals are plain level signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A write to a set address ORs the write data into its status register. A write to a clear address removes the write-data bits from it. Bits whose mask bit is 0 keep their value. The new value appears from the clock edge that takes the write.
- R2: Word addresses: status triples sit at base+0 (set), base+1 (clear) and base+2 (status). The bases are ownership 0, output enable 3, output data 6, pull-up 9, pull-down 12, open-drain 15, filter enable 18 and filter mode 21. Address 24 is select-low, 25 is select-high, 26 is Schmitt disable and 27 is the debounce divider; these four are read/write. Address 28 is pin status. Reads of set, clear and unused addresses return 0. Read data is combinational in the same cycle.
- R3: When ownership bit i is 1 (GPIO) and open-drain is off, pad_out[i] equals the output-data bit and pad_oe[i] equals the output-enable bit.
- R4: When ownership bit i is 0, the pin follows fn_dout[k][i] and fn_oe[k][i]. Here k = {select-high[i], select-low[i]}: 0 selects A, 1 selects B, 2 selects C and 3 selects D.
- R5: With open-drain bit i set, pad_out[i] is 0 and pad_oe[i] is the selected enable AND NOT the selected value, so a 1 releases the pin.
- R6: pad_pu equals the pull-up status. pad_pd equals the pull-down status with the pull-up bits masked out, so pull-up wins.
- R7: A read of pin status returns pad_in in the same cycle, for every pin regardless of owner.
- R8: fn_din[i] equals pad_in[i] while filter enable bit i is 0. Otherwise it is a filtered level that tracks the pin at all times. In glitch mode (filter-mode bit 0) the filtered level takes a new pad value only at a clock edge where that value matches the value sampled at the previous edge.
- R9: In debounce mode (filter-mode bit 1) a free-running strobe fires once every divider+1 clocks. The filtered level takes a new pad value only at a strobe where it matches the value sampled at the previous strobe.
- R10: After reset every pin is GPIO-owned, outputs are disabled, output data is 0 and pull-ups are on. Pull-downs, open-drain, filters, filter mode, selects (function A), Schmitt disable and the divider are all 0.
- R11: pad_st_dis equals the Schmitt-disable register.
- R12: Writes to pin status or to unused addresses change no register, and a status register with no write to its set or clear address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | N | Write data / pin mask |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | N | Read data for reg_addr |
| pad_in | input | N | Raw pad level |
| pad_out | output | N | Pad output value |
| pad_oe | output | N | Pad output enable |
| pad_pu | output | N | Pull-up enable |
| pad_pd | output | N | Pull-down enable |
| pad_st_dis | output | N | Schmitt-trigger disable |
| fn_dout | input | 4xN | Output value from functions A..D |
| fn_oe | input | 4xN | Output enable from functions A..D |
| fn_din | output | N | Input level, optionally filtered, to the functions |

## Verification
A register write becomes visible one edge later: from that edge the status read and the pad controls derived from it show the new value. Changes on pad_in, fn_dout and fn_oe reach reg_rdata, pad_out and pad_oe in the same cycle. A glitch-filtered input moves no earlier than the second edge that sees a new level, and a debounce-filtered input moves only at a divider strobe. The bench keeps its own model state, steps it at each rising edge and compares every output three tenths of a period later, after the edge has taken effect and before the next input change. Stimulus includes single-cycle pulses, to show the filters reject them, and divider changes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned NUM_BANKS = 8;
  localparam int unsigned NUM_FN    = 4;

  localparam int unsigned BK_OWN   = 0;
  localparam int unsigned BK_OE    = 1;
  localparam int unsigned BK_DAT   = 2;
  localparam int unsigned BK_PU    = 3;
  localparam int unsigned BK_PD    = 4;
  localparam int unsigned BK_ODRN  = 5;
  localparam int unsigned BK_FEN   = 6;
  localparam int unsigned BK_FMODE = 7;

  localparam int unsigned A_SEL_LO = 24;
  localparam int unsigned A_SEL_HI = 25;
  localparam int unsigned A_STDIS  = 26;
  localparam int unsigned A_DIV    = 27;
  localparam int unsigned A_PINS   = 28;

  typedef enum logic [1:0] {
    FN_A = 2'd0,
    FN_B = 2'd1,
    FN_C = 2'd2,
    FN_D = 2'd3
  } fn_sel_e;
endpackage

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int unsigned N        = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned BASE     = 0,
  parameter bit          RST_ONES = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      status
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(BASE + 1);

  logic hit_set, hit_clr;
  assign hit_set = we && (addr == A_SET);
  assign hit_clr = we && (addr == A_CLR);

  always_ff @(posedge clk) begin
    if (rst)          status <= {N{RST_ONES}};
    else if (hit_set) status <= status | wdata;
    else if (hit_clr) status <= status & ~wdata;
  end

  p_set_r1: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_SET) |=> status == ($past(status) | $past(wdata)));
  p_clr_r1: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_CLR) |=> status == ($past(status) & ~$past(wdata)));
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !(we && (addr == A_SET || addr == A_CLR)) |=> $stable(status));
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int unsigned N     = 32,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pin_in,
  input  logic [N-1:0]     en,
  input  logic [N-1:0]     debounce,
  input  logic [DIV_W-1:0] div,
  output logic [N-1:0]     fn_din
);
  logic [DIV_W-1:0] cnt;
  logic             tick;
  logic [N-1:0]     g_prev, d_prev, lvl_q;
  logic [N-1:0]     upd_g, upd_d, upd;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assign upd_g = ~(pin_in ^ g_prev);
  assign upd_d = {N{tick}} & ~(pin_in ^ d_prev);
  assign upd   = (debounce & upd_d) | (~debounce & upd_g);

  always_ff @(posedge clk) begin
    if (rst) begin
      g_prev <= '0;
      d_prev <= '0;
      lvl_q  <= '0;
    end else begin
      g_prev <= pin_in;
      if (tick) d_prev <= pin_in;
      lvl_q <= (upd & pin_in) | (~upd & lvl_q);
    end
  end

  assign fn_din = (en & lvl_q) | (~en & pin_in);

  // A glitch-mode change must carry the level seen at the previous edge.
  p_glitch_r8: assert property (@(posedge clk) disable iff (rst)
    ((lvl_q ^ $past(lvl_q)) & ~$past(debounce) & (lvl_q ^ $past(pin_in))) == '0);
  // A debounce-mode change only happens on a strobe.
  p_debounce_r9: assert property (@(posedge clk) disable iff (rst)
    (((lvl_q ^ $past(lvl_q)) & $past(debounce)) != '0) |-> $past(tick));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]             own,
  input  logic [N-1:0]             oe,
  input  logic [N-1:0]             dat,
  input  logic [N-1:0]             odrn,
  input  logic [N-1:0]             sel_lo,
  input  logic [N-1:0]             sel_hi,
  input  logic [NUM_FN-1:0][N-1:0] fn_dout,
  input  logic [NUM_FN-1:0][N-1:0] fn_oe,
  output logic [N-1:0]             pad_out,
  output logic [N-1:0]             pad_oe
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    fn_sel_e sel;
    logic    v, e;
    always_comb begin
      sel = fn_sel_e'({sel_hi[i], sel_lo[i]});
      if (own[i]) begin
        v = dat[i];
        e = oe[i];
      end else begin
        v = fn_dout[sel][i];
        e = fn_oe[sel][i];
      end
      if (odrn[i]) begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = e & ~v;
      end else begin
        pad_out[i] = v;
        pad_oe[i]  = e;
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter int unsigned DIV_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [N-1:0]             reg_wdata,
  input  logic                     reg_we,
  output logic [N-1:0]             reg_rdata,
  input  logic [N-1:0]             pad_in,
  output logic [N-1:0]             pad_out,
  output logic [N-1:0]             pad_oe,
  output logic [N-1:0]             pad_pu,
  output logic [N-1:0]             pad_pd,
  output logic [N-1:0]             pad_st_dis,
  input  logic [NUM_FN-1:0][N-1:0] fn_dout,
  input  logic [NUM_FN-1:0][N-1:0] fn_oe,
  output logic [N-1:0]             fn_din
);
  localparam int unsigned STAT_OFS = 2;

  logic [NUM_BANKS-1:0][N-1:0] bank_q;
  logic [N-1:0]                sel_lo_q, sel_hi_q, stdis_q;
  logic [DIV_W-1:0]            div_q;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    gpio_setclr_bank #(
      .N       (N),
      .ADDR_W  (ADDR_W),
      .BASE    (3 * k),
      .RST_ONES(k == BK_OWN || k == BK_PU)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (reg_we),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .status(bank_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      stdis_q  <= '0;
      div_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_W'(A_SEL_LO): sel_lo_q <= reg_wdata;
        ADDR_W'(A_SEL_HI): sel_hi_q <= reg_wdata;
        ADDR_W'(A_STDIS):  stdis_q  <= reg_wdata;
        ADDR_W'(A_DIV):    div_q    <= reg_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (reg_addr == ADDR_W'(3 * k + STAT_OFS)) reg_rdata = bank_q[k];
    end
    case (reg_addr)
      ADDR_W'(A_SEL_LO): reg_rdata = sel_lo_q;
      ADDR_W'(A_SEL_HI): reg_rdata = sel_hi_q;
      ADDR_W'(A_STDIS):  reg_rdata = stdis_q;
      ADDR_W'(A_DIV):    reg_rdata = N'(div_q);
      ADDR_W'(A_PINS):   reg_rdata = pad_in;
      default: ;
    endcase
  end

  gpio_pad_mux #(.N(N)) u_mux (
    .own    (bank_q[BK_OWN]),
    .oe     (bank_q[BK_OE]),
    .dat    (bank_q[BK_DAT]),
    .odrn   (bank_q[BK_ODRN]),
    .sel_lo (sel_lo_q),
    .sel_hi (sel_hi_q),
    .fn_dout(fn_dout),
    .fn_oe  (fn_oe),
    .pad_out(pad_out),
    .pad_oe (pad_oe)
  );

  gpio_in_filter #(.N(N), .DIV_W(DIV_W)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .pin_in  (pad_in),
    .en      (bank_q[BK_FEN]),
    .debounce(bank_q[BK_FMODE]),
    .div     (div_q),
    .fn_din  (fn_din)
  );

  assign pad_pu     = bank_q[BK_PU];
  assign pad_pd     = bank_q[BK_PD] & ~bank_q[BK_PU];
  assign pad_st_dis = stdis_q;

  p_gpio_r3: assert property (@(posedge clk) disable iff (rst)
    ((bank_q[BK_OWN] & ~bank_q[BK_ODRN] & (pad_out ^ bank_q[BK_DAT])) == '0) &&
    ((bank_q[BK_OWN] & ~bank_q[BK_ODRN] & (pad_oe ^ bank_q[BK_OE])) == '0));
  p_od_r5: assert property (@(posedge clk) disable iff (rst)
    (pad_out & bank_q[BK_ODRN]) == '0);
  p_pull_r6: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);
  p_pins_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(A_PINS)) |-> reg_rdata == pad_in);
  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bank_q[BK_OWN] == '1 && pad_oe == '0 && pad_pu == '1 && div_q == '0));
endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE_DLY = CLK_PERIOD * 3 / 10;

  logic              clk = 1'b0;
  logic              rst;
  logic [4:0]        reg_addr;
  logic [31:0]       reg_wdata;
  logic              reg_we;
  logic [31:0]       reg_rdata;
  logic [31:0]       pad_in;
  logic [31:0]       pad_out, pad_oe, pad_pu, pad_pd, pad_st_dis, fn_din;
  logic [3:0][31:0]  fn_dout, fn_oe;

  int n_checks = 0;
  int n_errors = 0;

  // reference model state
  logic [31:0] m_bank [8];
  logic [31:0] m_sel_lo, m_sel_hi, m_st, m_gp, m_dp, m_lvl;
  logic [7:0]  m_div;
  int          m_cnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_st_dis(pad_st_dis), .fn_dout(fn_dout), .fn_oe(fn_oe), .fn_din(fn_din)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic model_step();
    bit tick;
    if (rst) begin
      for (int k = 0; k < 8; k++) m_bank[k] = 32'h0;
      m_bank[0] = 32'hFFFF_FFFF;
      m_bank[3] = 32'hFFFF_FFFF;
      m_sel_lo = 0; m_sel_hi = 0; m_st = 0; m_div = 0;
      m_cnt = 0; m_gp = 0; m_dp = 0; m_lvl = 0;
    end else begin
      tick = (m_cnt >= int'(m_div));
      for (int i = 0; i < 32; i++) begin
        if (m_bank[7][i]) begin
          if (tick && pad_in[i] == m_dp[i]) m_lvl[i] = pad_in[i];
        end else if (pad_in[i] == m_gp[i]) begin
          m_lvl[i] = pad_in[i];
        end
      end
      m_gp = pad_in;
      if (tick) m_dp = pad_in;
      m_cnt = tick ? 0 : m_cnt + 1;
      if (reg_we) begin
        if (reg_addr < 24) begin
          if (reg_addr % 3 == 0) m_bank[reg_addr / 3] = m_bank[reg_addr / 3] | reg_wdata;
          else if (reg_addr % 3 == 1) m_bank[reg_addr / 3] = m_bank[reg_addr / 3] & ~reg_wdata;
        end
        else if (reg_addr == 24) m_sel_lo = reg_wdata;
        else if (reg_addr == 25) m_sel_hi = reg_wdata;
        else if (reg_addr == 26) m_st = reg_wdata;
        else if (reg_addr == 27) m_div = reg_wdata[7:0];
      end
    end
  endtask

  task automatic compare_all();
    logic [31:0] e_out, e_oe, e_rd;
    for (int i = 0; i < 32; i++) begin
      int  idx;
      logic v, e;
      idx = (m_sel_hi[i] ? 2 : 0) + (m_sel_lo[i] ? 1 : 0);
      v = m_bank[0][i] ? m_bank[2][i] : fn_dout[idx][i];
      e = m_bank[0][i] ? m_bank[1][i] : fn_oe[idx][i];
      e_out[i] = m_bank[5][i] ? 1'b0 : v;
      e_oe[i]  = m_bank[5][i] ? (e & ~v) : e;
    end
    e_rd = 32'h0;
    if (reg_addr < 24 && reg_addr % 3 == 2) e_rd = m_bank[reg_addr / 3];
    else if (reg_addr == 24) e_rd = m_sel_lo;
    else if (reg_addr == 25) e_rd = m_sel_hi;
    else if (reg_addr == 26) e_rd = m_st;
    else if (reg_addr == 27) e_rd = {24'h0, m_div};
    else if (reg_addr == 28) e_rd = pad_in;
    chk("R3/R4/R5 pad_out", pad_out, e_out);
    chk("R3/R4/R5 pad_oe", pad_oe, e_oe);
    chk("R6 pad_pu", pad_pu, m_bank[3]);
    chk("R6 pad_pd", pad_pd, m_bank[4] & ~m_bank[3]);
    chk("R11 pad_st_dis", pad_st_dis, m_st);
    chk("R8/R9 fn_din", fn_din, (m_bank[6] & m_lvl) | (~m_bank[6] & pad_in));
    if (reg_addr == 28) chk("R7 pin status", reg_rdata, e_rd);
    else chk("R1/R2/R12 reg_rdata", reg_rdata, e_rd);
  endtask

  always @(posedge clk) begin
    model_step();
    #(SAMPLE_DLY);
    compare_all();
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic look(input int a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = 5'(a);
    @(posedge clk);
    #(CLK_PERIOD / 2 - 1);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic sweep();
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      reg_addr = 5'(a);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_addr = 5'd0; reg_wdata = 32'h0;
    pad_in = 32'h0;
    fn_dout[0] = 32'hAAAA_AAAA; fn_dout[1] = 32'h5555_5555;
    fn_dout[2] = 32'h0F0F_0F0F; fn_dout[3] = 32'h3C3C_3C3C;
    fn_oe[0] = 32'hFFFF_0000; fn_oe[1] = 32'h00FF_FF00;
    fn_oe[2] = 32'hF0F0_F0F0; fn_oe[3] = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10: reset values through the register port
    look(2,  "R10 ownership", 32'hFFFF_FFFF);
    look(5,  "R10 output enable", 32'h0);
    look(11, "R10 pull-up", 32'hFFFF_FFFF);
    look(14, "R10 pull-down", 32'h0);
    look(23, "R10 filter mode", 32'h0);
    look(24, "R10 select low", 32'h0);
    look(27, "R10 divider", 32'h0);
    sweep();

    // R1 R3: masked GPIO output programming
    pad_in = 32'hDEAD_BEEF;
    wr(3, 32'h0000_FFFF);
    wr(6, 32'h00FF_00FF);
    wr(7, 32'h000F_000F);
    look(8, "R1 data after set/clear", 32'h00F0_00F0);
    wr(4, 32'h0000_0F00);
    look(5, "R1 oe after clear", 32'h0000_F0FF);

    // R4: hand upper pins to peripherals, exercise all four selects
    wr(1, 32'hF0F0_F0F0);
    wr(24, 32'hFF00_FF00);
    wr(25, 32'hFFFF_0000);
    repeat (3) @(negedge clk);
    fn_dout[1] = 32'h1234_5678;
    fn_oe[2]   = 32'h0F0F_1111;
    repeat (2) @(negedge clk);
    look(28, "R7 pin status with peripheral owner", 32'hDEAD_BEEF);
    pad_in = 32'h0BAD_F00D;
    look(28, "R7 pin status follows pad", 32'h0BAD_F00D);
    wr(0, 32'h0000_00F0);

    // R5: open-drain on a mix of GPIO and peripheral pins
    wr(15, 32'h00FF_FF00);
    wr(6, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    wr(7, 32'h0F0F_0F0F);
    wr(16, 32'h0000_F000);

    // R6: pull-up and pull-down overlap
    wr(10, 32'h0000_00FF);
    wr(12, 32'h0000_0F0F);
    look(14, "R6 pull-down status", 32'h0000_0F0F);

    // R11
    wr(26, 32'h1234_5678);

    // R12: writes to read-only / unused addresses
    wr(28, 32'hFFFF_FFFF);
    wr(30, 32'hFFFF_FFFF);
    wr(31, 32'hFFFF_FFFF);
    sweep();

    // R8 R9: filters. bits 0-7 debounce, bits 8-15 glitch, all enabled
    pad_in = 32'h0;
    wr(18, 32'h0000_FFFF);
    wr(21, 32'h0000_00FF);
    wr(27, 32'd3);
    repeat (10) @(negedge clk);
    pad_in = 32'h0000_FFFF;
    @(negedge clk);
    pad_in = 32'h0;
    repeat (10) @(negedge clk);
    pad_in = 32'h0000_FFFF;
    repeat (12) @(negedge clk);
    for (int c = 0; c < 120; c++) begin
      @(negedge clk);
      if (c % 5 == 0 || c % 11 == 3) pad_in = pad_in ^ 32'h0000_0505;
      if (c % 3 == 1) pad_in = pad_in ^ 32'h0000_3030;
      if (c == 60) begin
        reg_we = 1'b1; reg_addr = 5'd27; reg_wdata = 32'd0;
      end else if (c == 61) begin
        reg_we = 1'b0; reg_wdata = 32'h0;
      end
      if (c == 90) begin
        reg_we = 1'b1; reg_addr = 5'd22; reg_wdata = 32'h0000_000F;
      end else if (c == 91) begin
        reg_we = 1'b0; reg_wdata = 32'h0;
      end
    end
    wr(19, 32'h0000_00FF);
    repeat (5) @(negedge clk);
    sweep();

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule